// File: doc/BRIEF.md
# Multi-Master Doorbell Interrupt Array

This block holds a row of doorbells. Each doorbell belongs to one receiving processor, and any of up to 32 bus masters can ring it. A master rings a doorbell by writing to that doorbell's ring register. Every write carries the ID of the master that issued it. The doorbell keeps one bit per master ID, so the receiver can tell who rang it. A per-master enable mask decides which of those rings reach the receiver's interrupt line.

Software on the receiver works in three steps. It sets enable bits with a read-modify-write of the mask register. It reads the pending register to see which enabled masters have rung. It writes that same value back to clear exactly those bits. A doorbell keeps raising its level interrupt for as long as any pending bit remains.

The block has several write ports that work in parallel, one per attached bus, so a ring and a clear can land in the same cycle. It has one combinational read port.

Top module: `doorbell_array`

## Requirements
- R1: After reset, every doorbell's raw history and enable mask are zero, every interrupt output is low, and every register reads as zero.
- R2: A write to offset 0x0 of a doorbell with data bit 0 set sets bit `wr_mid` of that doorbell's raw history. A write there with data bit 0 clear changes nothing.
- R3: The raw history at offset 0x8 records a ring whether or not the master is enabled. The pending register at offset 0xC reads as raw AND enable.
- R4: A write to offset 0x4 replaces the whole enable mask, and the mask reads back at 0x4. A ring recorded while its master was disabled shows as pending, and raises the interrupt, as soon as its enable bit is set.
- R5: A write to offset 0xC clears each raw bit whose data bit is 1 and whose enable bit is 1. Raw bits of disabled masters, and bits written as 0, keep their values.
- R6: `irq[i]` is the OR of doorbell i's pending bits. It goes high in the cycle after the ring is taken and stays high until those bits are cleared or disabled.
- R7: If one port rings a master's bit while another port clears that same bit in the same cycle, the bit stays set. A clear of other bits in that cycle still takes effect.
- R8: Rings from several ports in one cycle are all recorded. If several ports write the enable mask in one cycle, the port with the highest index wins.
- R9: Writes to offset 0x8 have no effect, and offset 0x0 reads as zero. Offsets other than 0x0, 0x4, 0x8 and 0xC, and doorbell indices at or above NUM_BELLS, are ignored on write and read as zero.
- R10: Doorbell i sits at base address i*2^STRIDE_LOG2 (0x100 by default). A write to one doorbell never changes another.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_valid | input | NUM_PORTS | Write strobe per port |
| wr_addr | input | NUM_PORTS x ADDR_W | Write byte address per port |
| wr_data | input | NUM_PORTS x DATA_W | Write data per port |
| wr_mid | input | NUM_PORTS x MID_W | ID of the master that issued each write |
| rd_addr | input | ADDR_W | Read byte address |
| rd_data | output | DATA_W | Combinational read data |
| irq | output | NUM_BELLS | Level interrupt per doorbell |

## Verification
The hardest case to reach from the ports is a ring and a clear that hit the same bit in the same clock edge. A single bus cannot produce it. The bench drives both write ports in one cycle: port 0 writes the pending register and port 1 rings the same master. It then repeats this with a different master, so that one run shows both the ring winning and the clear still applying to other bits. The bench also sets up a ring while the master is disabled, then clears all pending bits. This proves that the history of a disabled master survives the clear and only shows once its enable bit is set.

// File: rtl/db_pkg.sv
package db_pkg;

    typedef enum logic [1:0] {
        SEL_RING = 2'd0,
        SEL_MASK = 2'd1,
        SEL_RAW  = 2'd2,
        SEL_PEND = 2'd3
    } reg_sel_e;

    typedef struct packed {
        logic     hit;
        reg_sel_e sel;
    } reg_hit_t;

    // Offset within one doorbell window; only 0x0/0x4/0x8/0xC are mapped.
    function automatic reg_hit_t decode_offset(input logic [15:0] ofs);
        reg_hit_t r;
        r.hit = (ofs[15:4] == 12'h000) && (ofs[1:0] == 2'b00);
        r.sel = reg_sel_e'(ofs[3:2]);
        return r;
    endfunction

endpackage

// File: rtl/db_port_decode.sv
module db_port_decode
    import db_pkg::*;
#(
    parameter int NUM_BELLS   = 4,
    parameter int NUM_MASTERS = 32,
    parameter int MID_W       = 5,
    parameter int ADDR_W      = 12,
    parameter int STRIDE_LOG2 = 8,
    parameter int DATA_W      = 32
) (
    input  logic                                  valid_i,
    input  logic [ADDR_W-1:0]                     addr_i,
    input  logic [DATA_W-1:0]                     data_i,
    input  logic [MID_W-1:0]                      mid_i,
    output logic [NUM_BELLS-1:0][NUM_MASTERS-1:0] ring_o,
    output logic [NUM_BELLS-1:0][NUM_MASTERS-1:0] clr_o,
    output logic [NUM_BELLS-1:0]                  mask_we_o,
    output logic [NUM_MASTERS-1:0]                mask_data_o
);

    localparam int IDX_W = ADDR_W - STRIDE_LOG2;

    logic [IDX_W-1:0] idx;
    reg_hit_t         hit;
    logic             mid_ok;
    logic [NUM_MASTERS-1:0] mid_onehot;

    always_comb begin
        idx        = addr_i[ADDR_W-1:STRIDE_LOG2];
        hit        = decode_offset(16'(addr_i[STRIDE_LOG2-1:0]));
        mid_ok     = ({1'b0, 32'(mid_i)} < {1'b0, 32'(NUM_MASTERS)});
        mid_onehot = NUM_MASTERS'(1) << mid_i;
    end

    assign mask_data_o = data_i[NUM_MASTERS-1:0];

    for (genvar b = 0; b < NUM_BELLS; b++) begin : g_bell
        logic sel_b;
        assign sel_b = valid_i && hit.hit && (idx == IDX_W'(b));
        assign ring_o[b] = (sel_b && hit.sel == SEL_RING && data_i[0] && mid_ok)
                           ? mid_onehot : '0;
        assign clr_o[b]  = (sel_b && hit.sel == SEL_PEND)
                           ? data_i[NUM_MASTERS-1:0] : '0;
        assign mask_we_o[b] = sel_b && (hit.sel == SEL_MASK);
    end

endmodule

// File: rtl/db_bell.sv
module db_bell #(
    parameter int NUM_MASTERS = 32,
    parameter int NUM_PORTS   = 2
) (
    input  logic                                  clk,
    input  logic                                  rst_n,
    input  logic [NUM_PORTS-1:0][NUM_MASTERS-1:0] ring_i,
    input  logic [NUM_PORTS-1:0][NUM_MASTERS-1:0] clr_i,
    input  logic [NUM_PORTS-1:0]                  mask_we_i,
    input  logic [NUM_PORTS-1:0][NUM_MASTERS-1:0] mask_data_i,
    output logic [NUM_MASTERS-1:0]                raw_o,
    output logic [NUM_MASTERS-1:0]                en_o,
    output logic [NUM_MASTERS-1:0]                pend_o,
    output logic                                  irq_o
);

    typedef struct packed {
        logic [NUM_MASTERS-1:0] raw;
        logic [NUM_MASTERS-1:0] en;
    } bell_state_t;

    bell_state_t            state_d, state_q;
    logic [NUM_MASTERS-1:0] ring_any;
    logic [NUM_MASTERS-1:0] clr_any;
    logic                   mask_any;

    always_comb begin
        ring_any = '0;
        clr_any  = '0;
        mask_any = 1'b0;
        state_d  = state_q;
        for (int p = 0; p < NUM_PORTS; p++) begin
            ring_any = ring_any | ring_i[p];
            clr_any  = clr_any | clr_i[p];
            mask_any = mask_any | mask_we_i[p];
            if (mask_we_i[p]) begin
                state_d.en = mask_data_i[p];  // later port overrides
            end
        end
        // clear only what is visible as pending; a ring in the same cycle wins
        state_d.raw = (state_q.raw & ~(clr_any & state_q.en)) | ring_any;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    assign raw_o  = state_q.raw;
    assign en_o   = state_q.en;
    assign pend_o = state_q.raw & state_q.en;
    assign irq_o  = |pend_o;

    // R2, R7: every accepted ring is present the next cycle, even against a clear
    a_r7_ring_wins: assert property (@(posedge clk) disable iff (!rst_n)
        (|ring_any) |=> ((state_q.raw & $past(ring_any)) == $past(ring_any)));

    // R2: a raw bit can only appear because of a ring
    a_r2_raw_needs_ring: assert property (@(posedge clk) disable iff (!rst_n)
        ((state_q.raw & ~$past(state_q.raw) & ~$past(ring_any)) == '0));

    // R4: the mask only moves on a mask write
    a_r4_mask_holds: assert property (@(posedge clk) disable iff (!rst_n)
        !mask_any |=> $stable(state_q.en));

    // R6: the interrupt only drops after a clear or a mask write
    a_r6_irq_drop_cause: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(irq_o) |-> ($past(|clr_any) || $past(mask_any)));

endmodule

// File: rtl/db_read_mux.sv
module db_read_mux
    import db_pkg::*;
#(
    parameter int NUM_BELLS   = 4,
    parameter int NUM_MASTERS = 32,
    parameter int ADDR_W      = 12,
    parameter int STRIDE_LOG2 = 8,
    parameter int DATA_W      = 32
) (
    input  logic [ADDR_W-1:0]                     rd_addr_i,
    input  logic [NUM_BELLS-1:0][NUM_MASTERS-1:0] raw_i,
    input  logic [NUM_BELLS-1:0][NUM_MASTERS-1:0] en_i,
    input  logic [NUM_BELLS-1:0][NUM_MASTERS-1:0] pend_i,
    output logic [DATA_W-1:0]                     rd_data_o
);

    localparam int IDX_W = ADDR_W - STRIDE_LOG2;

    logic [IDX_W-1:0] idx;
    reg_hit_t         hit;

    always_comb begin
        idx       = rd_addr_i[ADDR_W-1:STRIDE_LOG2];
        hit       = decode_offset(16'(rd_addr_i[STRIDE_LOG2-1:0]));
        rd_data_o = '0;
        for (int b = 0; b < NUM_BELLS; b++) begin
            if (hit.hit && idx == IDX_W'(b)) begin
                case (hit.sel)
                    SEL_MASK: rd_data_o = DATA_W'(en_i[b]);
                    SEL_RAW:  rd_data_o = DATA_W'(raw_i[b]);
                    SEL_PEND: rd_data_o = DATA_W'(pend_i[b]);
                    default:  rd_data_o = '0;
                endcase
            end
        end
    end

endmodule

// File: rtl/doorbell_array.sv
module doorbell_array #(
    parameter int NUM_BELLS   = 4,
    parameter int NUM_MASTERS = 32,
    parameter int NUM_PORTS   = 2,
    parameter int ADDR_W      = 12,
    parameter int STRIDE_LOG2 = 8,
    parameter int DATA_W      = 32,
    parameter int MID_W       = $clog2(NUM_MASTERS)
) (
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic [NUM_PORTS-1:0]             wr_valid,
    input  logic [NUM_PORTS-1:0][ADDR_W-1:0] wr_addr,
    input  logic [NUM_PORTS-1:0][DATA_W-1:0] wr_data,
    input  logic [NUM_PORTS-1:0][MID_W-1:0]  wr_mid,
    input  logic [ADDR_W-1:0]                rd_addr,
    output logic [DATA_W-1:0]                rd_data,
    output logic [NUM_BELLS-1:0]             irq
);

    logic [NUM_PORTS-1:0][NUM_BELLS-1:0][NUM_MASTERS-1:0] port_ring;
    logic [NUM_PORTS-1:0][NUM_BELLS-1:0][NUM_MASTERS-1:0] port_clr;
    logic [NUM_PORTS-1:0][NUM_BELLS-1:0]                  port_mask_we;
    logic [NUM_PORTS-1:0][NUM_MASTERS-1:0]                port_mask_data;

    logic [NUM_BELLS-1:0][NUM_PORTS-1:0][NUM_MASTERS-1:0] bell_ring;
    logic [NUM_BELLS-1:0][NUM_PORTS-1:0][NUM_MASTERS-1:0] bell_clr;
    logic [NUM_BELLS-1:0][NUM_PORTS-1:0]                  bell_mask_we;

    logic [NUM_BELLS-1:0][NUM_MASTERS-1:0] raw_q;
    logic [NUM_BELLS-1:0][NUM_MASTERS-1:0] en_q;
    logic [NUM_BELLS-1:0][NUM_MASTERS-1:0] pend;

    for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
        db_port_decode #(
            .NUM_BELLS  (NUM_BELLS),
            .NUM_MASTERS(NUM_MASTERS),
            .MID_W      (MID_W),
            .ADDR_W     (ADDR_W),
            .STRIDE_LOG2(STRIDE_LOG2),
            .DATA_W     (DATA_W)
        ) i_decode (
            .valid_i    (wr_valid[p]),
            .addr_i     (wr_addr[p]),
            .data_i     (wr_data[p]),
            .mid_i      (wr_mid[p]),
            .ring_o     (port_ring[p]),
            .clr_o      (port_clr[p]),
            .mask_we_o  (port_mask_we[p]),
            .mask_data_o(port_mask_data[p])
        );
    end

    for (genvar b = 0; b < NUM_BELLS; b++) begin : g_bell
        for (genvar p = 0; p < NUM_PORTS; p++) begin : g_gather
            assign bell_ring[b][p]    = port_ring[p][b];
            assign bell_clr[b][p]     = port_clr[p][b];
            assign bell_mask_we[b][p] = port_mask_we[p][b];
        end

        db_bell #(
            .NUM_MASTERS(NUM_MASTERS),
            .NUM_PORTS  (NUM_PORTS)
        ) i_bell (
            .clk        (clk),
            .rst_n      (rst_n),
            .ring_i     (bell_ring[b]),
            .clr_i      (bell_clr[b]),
            .mask_we_i  (bell_mask_we[b]),
            .mask_data_i(port_mask_data),
            .raw_o      (raw_q[b]),
            .en_o       (en_q[b]),
            .pend_o     (pend[b]),
            .irq_o      (irq[b])
        );
    end

    db_read_mux #(
        .NUM_BELLS  (NUM_BELLS),
        .NUM_MASTERS(NUM_MASTERS),
        .ADDR_W     (ADDR_W),
        .STRIDE_LOG2(STRIDE_LOG2),
        .DATA_W     (DATA_W)
    ) i_read (
        .rd_addr_i(rd_addr),
        .raw_i    (raw_q),
        .en_i     (en_q),
        .pend_i   (pend),
        .rd_data_o(rd_data)
    );

endmodule

// File: tb/test_doorbell_array.sv
module test_doorbell_array;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic [1:0]       wr_valid = '0;
    logic [1:0][11:0] wr_addr = '0;
    logic [1:0][31:0] wr_data = '0;
    logic [1:0][4:0]  wr_mid = '0;
    logic [11:0]      rd_addr = '0;
    logic [31:0]      rd_data;
    logic [3:0]       irq;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    always #2.5 clk = ~clk;  // 200 MHz

    doorbell_array i_doorbell_array (
        .clk(clk), .rst_n(rst_n),
        .wr_valid(wr_valid), .wr_addr(wr_addr), .wr_data(wr_data), .wr_mid(wr_mid),
        .rd_addr(rd_addr), .rd_data(rd_data), .irq(irq)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic put(input int p, input logic [11:0] a, input logic [31:0] d,
                       input logic [4:0] m);
        wr_valid[p] = 1'b1;
        wr_addr[p]  = a;
        wr_data[p]  = d;
        wr_mid[p]   = m;
    endtask

    task automatic tick;
        @(posedge clk);
        @(negedge clk);
        wr_valid = '0;
    endtask

    task automatic wr(input logic [11:0] a, input logic [31:0] d, input logic [4:0] m);
        put(0, a, d, m);
        tick();
    endtask

    task automatic rd_chk(input string req, input logic [11:0] a, input logic [31:0] exp);
        rd_addr = a;
        #1;
        check(req, rd_data, exp);
    endtask

    task automatic t_reset;
        for (int b = 0; b < 4; b++) begin
            for (int o = 0; o < 4; o++) begin
                rd_chk("R1 reset read", 12'(b * 256 + o * 4), 32'h0);
            end
        end
        check("R1 reset irq", 32'(irq), 32'h0);
    endtask

    task automatic t_ring_basic;
        wr(12'h004, 32'hFFFF_FFFF, 5'd0);
        wr(12'h000, 32'h1, 5'd5);
        rd_chk("R2 raw after ring", 12'h008, 32'h0000_0020);
        rd_chk("R3 pend after ring", 12'h00C, 32'h0000_0020);
        check("R6 irq high after ring", 32'(irq), 32'h1);
        check("R10 other bells untouched", 32'(irq[3:1]), 32'h0);
        rd_chk("R10 bell1 raw", 12'h108, 32'h0);
        wr(12'h000, 32'h2, 5'd6);
        rd_chk("R2 bit0 clear no ring", 12'h008, 32'h0000_0020);
        wr(12'h00C, 32'h0000_0020, 5'd0);
        rd_chk("R5 raw after clear", 12'h008, 32'h0);
        check("R6 irq low after clear", 32'(irq), 32'h0);
    endtask

    task automatic t_gate;
        wr(12'h104, 32'h0000_0001, 5'd0);
        wr(12'h100, 32'h1, 5'd3);
        rd_chk("R3 raw records disabled", 12'h108, 32'h0000_0008);
        rd_chk("R3 pend masks disabled", 12'h10C, 32'h0);
        check("R6 irq low when disabled", 32'(irq[1]), 32'h0);
        wr(12'h104, 32'h0000_0009, 5'd0);
        rd_chk("R4 mask readback", 12'h104, 32'h0000_0009);
        rd_chk("R4 pend on late enable", 12'h10C, 32'h0000_0008);
        check("R4 irq on late enable", 32'(irq[1]), 32'h1);
        wr(12'h104, 32'h0000_0001, 5'd0);
        check("R6 irq drops on disable", 32'(irq[1]), 32'h0);
        wr(12'h100, 32'h1, 5'd0);
        rd_chk("R3 raw two bits", 12'h108, 32'h0000_0009);
        wr(12'h10C, 32'hFFFF_FFFF, 5'd0);
        rd_chk("R5 disabled raw survives clear", 12'h108, 32'h0000_0008);
        check("R5 irq low after clear", 32'(irq[1]), 32'h0);
    endtask

    task automatic t_collide;
        wr(12'h204, 32'hFFFF_FFFF, 5'd0);
        wr(12'h200, 32'h1, 5'd7);
        put(0, 12'h20C, 32'h0000_0080, 5'd0);
        put(1, 12'h200, 32'h1, 5'd7);
        tick();
        rd_chk("R7 ring wins over clear", 12'h208, 32'h0000_0080);
        check("R7 irq stays high", 32'(irq[2]), 32'h1);
        put(0, 12'h20C, 32'h0000_0080, 5'd0);
        put(1, 12'h200, 32'h1, 5'd9);
        tick();
        rd_chk("R7 other clear applies", 12'h208, 32'h0000_0200);
    endtask

    task automatic t_dual;
        put(0, 12'h304, 32'h0000_AAAA, 5'd0);
        put(1, 12'h304, 32'h0000_5555, 5'd0);
        tick();
        rd_chk("R8 higher port mask wins", 12'h304, 32'h0000_5555);
        put(0, 12'h300, 32'h1, 5'd1);
        put(1, 12'h300, 32'h1, 5'd2);
        tick();
        rd_chk("R8 both rings recorded", 12'h308, 32'h0000_0006);
        rd_chk("R8 pend of both", 12'h30C, 32'h0000_0004);
    endtask

    task automatic t_ignored;
        wr(12'h308, 32'hFFFF_FFFF, 5'd0);
        rd_chk("R9 raw write ignored", 12'h308, 32'h0000_0006);
        rd_chk("R9 trigger reads zero", 12'h300, 32'h0);
        wr(12'h310, 32'hFFFF_FFFF, 5'd0);
        rd_chk("R9 unmapped offset reads zero", 12'h310, 32'h0);
        rd_chk("R9 unmapped write no effect", 12'h304, 32'h0000_5555);
        wr(12'h504, 32'h1234_5678, 5'd0);
        wr(12'h500, 32'h1, 5'd4);
        rd_chk("R9 absent bell reads zero", 12'h504, 32'h0);
        rd_chk("R10 bell0 mask intact", 12'h004, 32'hFFFF_FFFF);
        rd_chk("R10 bell0 raw intact", 12'h008, 32'h0);
        rd_chk("R10 bell1 mask intact", 12'h104, 32'h0000_0001);
        rd_chk("R10 bell3 raw intact", 12'h308, 32'h0000_0006);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_ring_basic();
        t_gate();
        t_collide();
        t_dual();
        t_ignored();
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog R1..R10 actual=hung expected=finished");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

endmodule